// File: doc/BRIEF.md
# PCI Interrupt Line to Legacy IRQ Router

This block steers the four level-sensitive PCI interrupt lines of a bridge (called lines A, B, C and D here) onto the sixteen request inputs of a legacy interrupt controller. Each line has its own 4-bit destination field, and these fields are packed into three bridge configuration bytes. The routing is purely combinational. The controller therefore sees a new destination in the same cycle that a configuration byte changes, and the old destination is released in that same cycle.

A destination value of zero disconnects a line. When several lines share one destination, their levels are merged as a wired OR. Destinations 2, 8 and 13 are reserved for system use. A line aimed at one of them still drives that request, but while such a line is asserted the block also raises an informational error level. The controller itself and the configuration write path sit outside this block.

Top module: `pirq_irq_router`

## Requirements
- R1: The destination of line A is bits [7:4] of configuration byte 0x55 (`cfg_b55`).
- R2: The destination of line B is bits [3:0] of byte 0x56 (`cfg_b56`), and the destination of line C is bits [7:4] of that byte.
- R3: The destination of line D is bits [7:4] of byte 0x57 (`cfg_b57`). Bits [3:0] of byte 0x55 and bits [3:0] of byte 0x57 have no effect on any output.
- R4: A line whose destination is 0 drives no request output, and `irq_lvl[0]` is never high.
- R5: Bit n of `irq_lvl` (n from 1 to 15) is high exactly when at least one asserted line has destination n.
- R6: A line routed to reserved destination 2, 8 or 13 drives that request bit in the same way as a legal destination.
- R7: `route_err` is high exactly while at least one asserted line has destination 2, 8 or 13. A line that is idle or disconnected never raises it.
- R8: Outputs follow the inputs combinationally. After a change to a destination field, the old request bit falls and the new one rises with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pirq_lvl | input | 4 | Levels of PCI interrupt lines A (bit 0) to D (bit 3), active high |
| cfg_b55 | input | 8 | Configuration byte holding the destination of line A |
| cfg_b56 | input | 8 | Configuration byte holding the destinations of lines B and C |
| cfg_b57 | input | 8 | Configuration byte holding the destination of line D |
| irq_lvl | output | 16 | Request levels toward the legacy interrupt controller, bit n = IRQ n |
| route_err | output | 1 | High while an asserted line uses a reserved destination |

## Verification
The embedded immediate assertions check several properties whenever the inputs settle. Request 0 stays low. The number of raised requests never exceeds the number of asserted lines. With every line idle, all outputs are quiet. A raised error always comes with at least one raised request. What the assertions cannot show is that each line reads its own nibble, that the unused nibbles are really ignored, and that the exact OR pattern is correct when lines share a destination. The bench's sweeps cover these points by comparing every request bit with an arithmetic model over every destination and every level pattern.

// File: rtl/pirq_route_pkg.sv
// Shared sizing and helpers for the interrupt line router.
// Assumes four lines and 4-bit destination fields.
package pirq_route_pkg;
    localparam int LINE_N  = 4;
    localparam int ROUTE_W = 4;
    localparam int IRQ_N   = 1 << ROUTE_W;
    localparam int CFG_W   = 8;

    typedef logic [ROUTE_W-1:0] route_t;

    // True for destinations that are reserved for system use.
    function automatic logic route_is_reserved(input route_t r);
        return (r == route_t'(2)) || (r == route_t'(8)) || (r == route_t'(13));
    endfunction
endpackage

// File: rtl/pirq_route_extract.sv
// Pulls the destination nibble of each line out of the three config bytes.
// Assumes the fixed field layout: A=b55[7:4], B=b56[3:0], C=b56[7:4], D=b57[7:4];
// the low nibbles of b55 and b57 are not read.
module pirq_route_extract
    import pirq_route_pkg::*;
#(
    parameter int CW = CFG_W
) (
    input  logic [CW-1:0] b55,
    input  logic [CW-1:0] b56,
    input  logic [CW-1:0] b57,
    output route_t        dest [LINE_N]
);
    localparam int HI = CW - 1;
    localparam int LO = CW - ROUTE_W;

    // Select the nibble for each line from its byte.
    always_comb begin
        dest[0] = b55[HI:LO];
        dest[1] = b56[ROUTE_W-1:0];
        dest[2] = b56[HI:LO];
        dest[3] = b57[HI:LO];
    end
endmodule

// File: rtl/pirq_irq_merge.sv
// Builds each request level as the OR of the asserted lines that point at it.
// Assumes destination 0 means disconnected, so request 0 is never driven.
module pirq_irq_merge
    import pirq_route_pkg::*;
#(
    parameter int NL = LINE_N,
    parameter int NI = IRQ_N
) (
    input  logic [NL-1:0] lvl,
    input  route_t        dest [NL],
    output logic [NI-1:0] irq
);
    // Request 0 is the disconnect code and never drives.
    assign irq[0] = 1'b0;

    for (genvar n = 1; n < NI; n++) begin : g_irq
        logic [NL-1:0] hit;
        for (genvar k = 0; k < NL; k++) begin : g_line
            // Line k contributes to request n when aimed at it and asserted.
            assign hit[k] = lvl[k] && (dest[k] == route_t'(n));
        end
        // Wired-OR merge of all contributing lines.
        assign irq[n] = |hit;
    end

    // Guard: the merged vector never holds more raised bits than asserted lines.
    always_comb begin
        assert_merge_fanout_R5: assert ($countones(irq) <= $countones(lvl))
            else $error("merge raised more requests than lines");
    end
endmodule

// File: rtl/pirq_reserved_check.sv
// Flags an asserted line that is aimed at a reserved destination.
// Assumes the flag is informational only; routing is not altered.
module pirq_reserved_check
    import pirq_route_pkg::*;
#(
    parameter int NL = LINE_N
) (
    input  logic [NL-1:0] lvl,
    input  route_t        dest [NL],
    output logic          err
);
    logic [NL-1:0] bad;

    for (genvar k = 0; k < NL; k++) begin : g_line
        // Line k is misrouted while asserted on a reserved destination.
        assign bad[k] = lvl[k] && route_is_reserved(dest[k]);
    end

    // Level-sensitive error: any misrouted asserted line.
    assign err = |bad;

    // Guard: an idle set of lines can never raise the flag.
    always_comb begin
        assert_idle_no_err_R7: assert (!((lvl == '0) && err))
            else $error("error flag with no asserted line");
    end
endmodule

// File: rtl/pirq_irq_router.sv
// Top of the PCI interrupt line to legacy IRQ router. Fully combinational:
// field extraction, wired-OR merge and reserved-destination detection.
// Assumes the config bytes are held stable by the configuration write path.
module pirq_irq_router
    import pirq_route_pkg::*;
(
    input  logic [LINE_N-1:0] pirq_lvl,
    input  logic [CFG_W-1:0]  cfg_b55,
    input  logic [CFG_W-1:0]  cfg_b56,
    input  logic [CFG_W-1:0]  cfg_b57,
    output logic [IRQ_N-1:0]  irq_lvl,
    output logic              route_err
);
    route_t dest [LINE_N];

    pirq_route_extract #(.CW(CFG_W)) u_extract (
        .b55  (cfg_b55),
        .b56  (cfg_b56),
        .b57  (cfg_b57),
        .dest (dest)
    );

    pirq_irq_merge #(.NL(LINE_N), .NI(IRQ_N)) u_merge (
        .lvl  (pirq_lvl),
        .dest (dest),
        .irq  (irq_lvl)
    );

    pirq_reserved_check #(.NL(LINE_N)) u_resv (
        .lvl  (pirq_lvl),
        .dest (dest),
        .err  (route_err)
    );

    // Cross-module guards on the settled outputs.
    always_comb begin
        assert_irq0_quiet_R4: assert (!irq_lvl[0])
            else $error("request 0 driven");
        assert_err_implies_drive_R6: assert (!route_err || (irq_lvl != '0))
            else $error("reserved route flagged but not driven");
        assert_idle_quiet_R5: assert (!((pirq_lvl == '0) && (irq_lvl != '0)))
            else $error("request raised with all lines idle");
    end
endmodule

// File: tb/pirq_irq_router_tb_top.sv
module pirq_irq_router_tb_top;
    logic        clk = 1'b0;
    logic [3:0]  lvl;
    logic [7:0]  b55, b56, b57;
    logic [15:0] irq;
    logic        err;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pirq_irq_router dut_i (
        .pirq_lvl (lvl), .cfg_b55 (b55), .cfg_b56 (b56), .cfg_b57 (b57),
        .irq_lvl (irq), .route_err (err)
    );

    // Drive at the falling edge, settle, then sample.
    task automatic drive(input logic [3:0] l, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c);
        @(negedge clk);
        lvl = l; b55 = a; b56 = b; b57 = c;
        #1;
    endtask

    function automatic logic resv(input logic [3:0] r);
        return (r == 4'd2) || (r == 4'd8) || (r == 4'd13);
    endfunction

    // Compare both outputs with an arithmetic model of the requirements.
    task automatic compare(input string tag);
        logic [3:0]  r [4];
        logic [15:0] e_irq = '0;
        logic        e_err = 1'b0;
        r[0] = b55[7:4]; r[1] = b56[3:0]; r[2] = b56[7:4]; r[3] = b57[7:4];
        for (int k = 0; k < 4; k++) begin
            if (lvl[k] && r[k] != 4'd0) e_irq[r[k]] = 1'b1;
            if (lvl[k] && resv(r[k])) e_err = 1'b1;
        end
        total++;
        if (irq !== e_irq) begin
            bad++;
            $display("FAIL %s irq: actual=%h expected=%h", tag, irq, e_irq);
        end
        total++;
        if (err !== e_err) begin
            bad++;
            $display("FAIL %s/R7 err: actual=%b expected=%b", tag, err, e_err);
        end
    endtask

    // Direct check of a single request bit.
    task automatic expect_bit(input string tag, input int n, input logic v);
        total++;
        if (irq[n] !== v) begin
            bad++;
            $display("FAIL %s irq[%0d]: actual=%b expected=%b", tag, n, irq[n], v);
        end
    endtask

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        logic [15:0] snap;
        // All inputs quiet: all outputs quiet (R4, R5, R7).
        drive(4'h0, 8'h00, 8'h00, 8'h00);
        compare("R4 idle");
        total++;
        if (irq !== 16'h0 || err !== 1'b0) begin
            bad++;
            $display("FAIL R5 idle: actual=%h/%b expected=0000/0", irq, err);
        end
        // Each line alone, every destination, both levels (R1, R2, R3, R4, R6).
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 16; d++) begin
                for (int v = 0; v < 2; v++) begin
                    logic [7:0] a = 8'h00, b = 8'h00, c = 8'h00;
                    case (k)
                        0: a = {d[3:0], 4'h0};
                        1: b = {4'h0, d[3:0]};
                        2: b = {d[3:0], 4'h0};
                        default: c = {d[3:0], 4'h0};
                    endcase
                    drive(v[0] ? 4'(1 << k) : 4'h0, a, b, c);
                    case (k)
                        0: compare("R1 lineA");
                        1: compare("R2 lineB");
                        2: compare("R2 lineC");
                        default: compare("R3 lineD");
                    endcase
                    if (v == 1 && d != 0) expect_bit("R6 drive", d, 1'b1);
                    if (d == 0) expect_bit("R4 disc", 0, 1'b0);
                end
            end
        end
        // Shared destination: OR merge (R5), one line drops out.
        drive(4'hF, 8'h50, 8'h55, 8'h50);
        compare("R5 all-to-5");
        drive(4'h6, 8'h50, 8'h55, 8'h50);
        compare("R5 two-to-5");
        expect_bit("R5 or", 5, 1'b1);
        // Ignored nibbles (R3): flipping low nibbles of b55/b57 changes nothing.
        drive(4'hF, 8'h30, 8'h74, 8'hB0);
        snap = irq;
        drive(4'hF, 8'h3F, 8'h74, 8'hBF);
        total++;
        if (irq !== snap) begin
            bad++;
            $display("FAIL R3 ignored nibble: actual=%h expected=%h", irq, snap);
        end
        // Route change moves the request with no clock edge (R8).
        drive(4'h1, 8'h90, 8'h00, 8'h00);
        #1 b55 = 8'hA0;
        #1;
        expect_bit("R8 old", 9, 1'b0);
        expect_bit("R8 new", 10, 1'b1);
        // Reserved destination with line idle: no error (R7).
        drive(4'hE, 8'hD0, 8'h00, 8'h00);
        compare("R7 idle-reserved");
        // Pseudo-random sweep of routes, all level patterns (R1..R8).
        for (int i = 0; i < 1500; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            for (int l = 0; l < 16; l++) begin
                drive(4'(l), seed[7:0], seed[15:8], seed[23:16]);
                compare("R5 sweep");
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule